// File: doc/BRIEF.md
# Two-Bank Interleaved Word Memory Controller

This controller sits between a processor-side request port and two independent storage banks. Each bank has its own address bus, and the controller drives both buses. The least significant bit of a word address picks the bank. The remaining upper bits form the row inside that bank.

Every accepted read does two things. It addresses its own bank, and it places the next sequential word on the opposite bank's bus in the same cycle. That opposite bank is then already producing the following word when the processor asks for it. A read that lands on this pending look-ahead word completes with no wait state. Any other read pays a single wait state: a repeat of the same bank, a jump, or the first read after a cancellation. During that wait state `req_ready` is low.

Writes are posted. They complete in their acceptance cycle and produce no response. A write to the bank that holds the look-ahead word takes over that bank's bus, so the look-ahead is dropped.

Internally, each bank is a synchronous RAM that registers its read data. Together with the controller's registered address bus, this gives a fixed two-cycle path from accepting a request to having its data.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: Out of reset, `req_ready` is 1, `rsp_valid` is 0, `rsp_rdata` is 0, and both bank address buses are 0. No look-ahead word is pending.
- R2: A request for word address A is steered to bank A[0] (0 for even, 1 for odd). After the request is accepted, that bank's address bus carries A[AW-1:1] in the following cycle.
- R3: After any read of address A is accepted, the other bank's bus carries the row of (A+1) modulo 2^AW in the following cycle. That word becomes the pending look-ahead. The highest address wraps to bank 0, row 0.
- R4: A read whose address equals the pending look-ahead word completes with zero wait states. `rsp_valid` is 1 with the word's data in the cycle right after acceptance, and `req_ready` stays 1.
- R5: A read that does not match the pending look-ahead word takes one wait state. In the cycle after acceptance, `req_ready` and `rsp_valid` are 0. In the next cycle, `rsp_valid` is 1 with the data and `req_ready` is 1 again.
- R6: Two consecutive reads to the same bank never benefit from look-ahead. The second one always takes the single wait state, including a repeated read of the same address.
- R7: A write is accepted without a wait state and produces no response. Its data is returned by every later read of that address.
- R8: A write to the bank that holds the pending look-ahead word cancels that word, whether or not the write addresses it. The next read of the cancelled word takes the wait state and returns current contents.
- R9: A write to the bank opposite the look-ahead word leaves the look-ahead pending. A following read of it still completes with zero wait states.
- R10: Whenever `rsp_valid` is 0, `rsp_rdata` is 0. Each accepted read produces exactly one response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request this cycle (low during a wait state) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_rdata | output | DW | Read data, zero when not valid |
| bank0_addr | output | AW-1 | Address bus driven to the even bank |
| bank1_addr | output | AW-1 | Address bus driven to the odd bank |

## Verification
The assertions assume the processor side follows the handshake: a request is taken only on a cycle where `req_ready` is high, and `req_valid` is low while reset is applied. The bench drives inputs on the falling edge. It presents a new request only after it has seen `req_ready` high, and it withdraws a read that stalls during its wait cycle. The timing properties, and the look-ahead address property that uses the previous cycle's address, therefore refer only to accepted transfers. Memory contents are always initialised by a full write sweep before any read, so every data comparison has a defined expected value.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Classification of the transfer taken in the current cycle.
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_HIT   = 2'd1,
    ACC_MISS  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/ilv_bank_ram.sv
// One bank: read data registered once per clock from the address bus.
module ilv_bank_ram #(
  parameter int RW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic [RW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << RW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/ilv_sched.sv
// Request classification, look-ahead tracking and bank bus registers.
module ilv_sched
  import ilv_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic                 rsp_bank,
  output logic [1:0][AW-2:0]   bus_addr,
  output logic [1:0]           bus_we,
  output logic [DW-1:0]        bus_wdata,
  output logic                 ev_hit,
  output logic                 ev_miss,
  output logic                 ev_write
);

  localparam int RW = AW - 1;

  function automatic logic bank_of(input logic [AW-1:0] a);
    return a[0];
  endfunction

  function automatic logic [RW-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:1];
  endfunction

  function automatic logic [AW-1:0] next_of(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic               wait_q;
  logic               rsp_q;
  logic               rsp_bank_q;
  logic               la_valid;
  logic [AW-1:0]      la_addr;
  logic [1:0][RW-1:0] bus_addr_q;
  logic [1:0]         bus_we_q;
  logic [DW-1:0]      wdata_q;

  logic               fire;
  logic [AW-1:0]      nxt;
  acc_kind_e          kind;

  assign req_ready = !wait_q;
  assign fire      = req_valid && req_ready;
  assign nxt       = next_of(req_addr);

  always_comb begin
    kind = ACC_NONE;
    if (fire) begin
      if (req_write)                          kind = ACC_WRITE;
      else if (la_valid && req_addr == la_addr) kind = ACC_HIT;
      else                                    kind = ACC_MISS;
    end
  end

  assign ev_hit   = (kind == ACC_HIT);
  assign ev_miss  = (kind == ACC_MISS);
  assign ev_write = (kind == ACC_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q     <= 1'b0;
      rsp_q      <= 1'b0;
      rsp_bank_q <= 1'b0;
      la_valid   <= 1'b0;
      la_addr    <= '0;
      bus_addr_q <= '0;
      bus_we_q   <= '0;
      wdata_q    <= '0;
    end else begin
      bus_we_q <= '0;
      rsp_q    <= 1'b0;
      if (wait_q) begin
        wait_q <= 1'b0;
        rsp_q  <= 1'b1;
      end
      case (kind)
        ACC_HIT: begin
          rsp_q                      <= 1'b1;
          rsp_bank_q                 <= bank_of(req_addr);
          la_addr                    <= nxt;
          la_valid                   <= 1'b1;
          bus_addr_q[bank_of(nxt)]   <= row_of(nxt);
        end
        ACC_MISS: begin
          wait_q                        <= 1'b1;
          rsp_bank_q                    <= bank_of(req_addr);
          bus_addr_q[bank_of(req_addr)] <= row_of(req_addr);
          la_addr                       <= nxt;
          la_valid                      <= 1'b1;
          bus_addr_q[bank_of(nxt)]      <= row_of(nxt);
        end
        ACC_WRITE: begin
          bus_addr_q[bank_of(req_addr)] <= row_of(req_addr);
          bus_we_q[bank_of(req_addr)]   <= 1'b1;
          wdata_q                       <= req_wdata;
          if (la_valid && bank_of(la_addr) == bank_of(req_addr))
            la_valid <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_bank  = rsp_bank_q;
  assign bus_addr  = bus_addr_q;
  assign bus_we    = bus_we_q;
  assign bus_wdata = wdata_q;

endmodule

// File: rtl/ilv_mem_ctrl.sv
// Top: two interleaved banks behind one request port.
module ilv_mem_ctrl #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-2:0] bank0_addr,
  output logic [AW-2:0] bank1_addr
);

  localparam int RW     = AW - 1;
  localparam int NBANKS = 2;

  logic                    rsp_bank;
  logic [NBANKS-1:0][RW-1:0] bus_addr;
  logic [NBANKS-1:0]       bus_we;
  logic [DW-1:0]           bus_wdata;
  logic [NBANKS-1:0][DW-1:0] bank_rdata;
  logic                    ev_hit;
  logic                    ev_miss;
  logic                    ev_write;

  ilv_sched #(.AW(AW), .DW(DW)) sched_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_bank  (rsp_bank),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .ev_hit    (ev_hit),
    .ev_miss   (ev_miss),
    .ev_write  (ev_write)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    ilv_bank_ram #(.RW(RW), .DW(DW)) ram_i (
      .clk   (clk),
      .addr  (bus_addr[b]),
      .we    (bus_we[b]),
      .wdata (bus_wdata),
      .rdata (bank_rdata[b])
    );
  end

  assign rsp_rdata  = rsp_valid ? bank_rdata[rsp_bank] : '0;
  assign bank0_addr = bus_addr[0];
  assign bank1_addr = bus_addr[1];

endmodule

// File: rtl/ilv_mem_chk.sv
// Timing and bus properties, attached to the top by bind.
module ilv_mem_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic [AW-2:0] bank0_addr,
  input logic [AW-2:0] bank1_addr,
  input logic          ev_hit,
  input logic          ev_miss,
  input logic          ev_write
);

  logic [AW-1:0] succ_w;
  assign succ_w = req_addr + AW'(1);

  // R4
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (rsp_valid && req_ready));

  // R5
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (!req_ready && !rsp_valid));

  // R5
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (req_ready && rsp_valid));

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> (req_ready && !rsp_valid));

  // R3
  lookahead_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit || ev_miss) |=>
      (($past(succ_w[0]) ? bank1_addr : bank0_addr) == $past(succ_w[AW-1:1])));

  // R2
  own_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss || ev_write) |=>
      (($past(req_addr[0]) ? bank1_addr : bank0_addr) == $past(req_addr[AW-1:1])));

  // R10
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0));

endmodule

bind ilv_mem_ctrl ilv_mem_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .bank0_addr (bank0_addr),
  .bank1_addr (bank1_addr),
  .ev_hit     (ev_hit),
  .ev_miss    (ev_miss),
  .ev_write   (ev_write)
);

// File: tb/ilv_mem_ctrl_tb_top.sv
module ilv_mem_ctrl_tb_top;

  localparam int AW    = 5;
  localparam int DW    = 16;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-2:0] bank0_addr;
  logic [AW-2:0] bank1_addr;

  always #5 clk = ~clk;

  ilv_mem_ctrl #(.AW(AW), .DW(DW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .bank0_addr (bank0_addr),
    .bank1_addr (bank1_addr)
  );

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  // Reference state, kept from the requirements only.
  logic [DW-1:0] mem_m [WORDS];
  bit            la_v = 0;
  int            la_a = 0;

  function automatic logic [DW-1:0] pattern(input int a, input int gen);
    return DW'(a * 731 + gen * 97 + 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int bus_of(input int bank);
    return (bank == 1) ? int'(bank1_addr) : int'(bank0_addr);
  endfunction

  // Called at a falling edge; returns at a falling edge.
  task automatic xfer(input bit w, input int a, input logic [DW-1:0] d, input string ctx);
    bit hit;
    int nx;
    hit = !w && la_v && (a == la_a);
    nx  = (a + 1) % WORDS;
    chk(req_ready == 1'b1, {ctx, " R5 ready before issue"}, int'(req_ready), 1);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = AW'(a);
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    chk(bus_of(a % 2) == a / 2, {ctx, " R2 own bank bus"}, bus_of(a % 2), a / 2);
    if (w) begin
      mem_m[a] = d;
      if (la_v && (la_a % 2) == (a % 2)) la_v = 0;
      chk(req_ready && !rsp_valid, {ctx, " R7 write no stall/no resp"},
          int'({req_ready, rsp_valid}), 2);
    end else begin
      la_a = nx;
      la_v = 1;
      chk(bus_of(nx % 2) == nx / 2, {ctx, " R3 look-ahead bus"}, bus_of(nx % 2), nx / 2);
      if (hit) begin
        chk(rsp_valid && req_ready, {ctx, " R4 zero-wait response"},
            int'({req_ready, rsp_valid}), 3);
        chk(rsp_rdata == mem_m[a], {ctx, " R4 hit data"}, int'(rsp_rdata), int'(mem_m[a]));
      end else begin
        chk(!req_ready && !rsp_valid, {ctx, " R5 wait cycle"},
            int'({req_ready, rsp_valid}), 0);
        chk(rsp_rdata == '0, {ctx, " R10 data zero in wait"}, int'(rsp_rdata), 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid && req_ready, {ctx, " R5 response after wait"},
            int'({req_ready, rsp_valid}), 3);
        chk(rsp_rdata == mem_m[a], {ctx, " R5 miss data"}, int'(rsp_rdata), int'(mem_m[a]));
      end
    end
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && rsp_rdata == '0, "R10 idle quiet", int'(rsp_rdata), 0);
  endtask

  task automatic expect_hit(input int a, input bit exp_hit, input string tag);
    bit h;
    h = la_v && (a == la_a);
    chk(h == exp_hit, {tag, " model classification"}, int'(h), int'(exp_hit));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && rsp_rdata == '0, "R1 reset port state",
        int'({req_ready, rsp_valid}), 2);
    chk(bank0_addr == '0 && bank1_addr == '0, "R1 reset buses",
        int'({bank1_addr, bank0_addr}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill every word.
    for (int a = 0; a < WORDS; a++) xfer(1'b1, a, pattern(a, 0), "fill R7");
    idle();

    // Ascending sweep with wrap: first read waits, the rest stream.
    for (int i = 0; i <= WORDS; i++) xfer(1'b0, i % WORDS, '0, "ascend R3 R4");
    idle();

    // Same-bank stride: every read waits.
    for (int a = 0; a < WORDS; a += 2) begin
      expect_hit(a, 1'b0, "R6 even stride");
      xfer(1'b0, a, '0, "R6 even stride");
    end
    for (int a = 1; a < WORDS; a += 2) xfer(1'b0, a, '0, "R6 odd stride");
    xfer(1'b0, 7, '0, "R6 repeat");
    expect_hit(7, 1'b0, "R6 repeat");
    xfer(1'b0, 7, '0, "R6 repeat");
    idle();

    // Alternating banks but not sequential: one wait each.
    for (int a = 0; a < WORDS; a += 3) xfer(1'b0, a, '0, "R5 jump");
    idle();

    // Write to the look-ahead bank cancels the look-ahead.
    for (int n = 0; n < 8; n++) begin
      int b0 = (n * 4) % WORDS;
      xfer(1'b0, b0, '0, "R8 setup");
      xfer(1'b1, (b0 + 1) % WORDS, pattern(b0 + 1, 1), "R8 write la word");
      expect_hit((b0 + 1) % WORDS, 1'b0, "R8 cancelled");
      xfer(1'b0, (b0 + 1) % WORDS, '0, "R8 reread");
      xfer(1'b0, (b0 + 2) % WORDS, '0, "R8 setup2");
      xfer(1'b1, (b0 + 5) % WORDS, pattern(b0 + 5, 2), "R8 write la bank");
      expect_hit((b0 + 3) % WORDS, 1'b0, "R8 bank cancel");
      xfer(1'b0, (b0 + 3) % WORDS, '0, "R8 reread2");
    end
    idle();

    // Write to the opposite bank keeps the look-ahead.
    for (int n = 0; n < WORDS; n += 5) begin
      xfer(1'b0, n, '0, "R9 setup");
      xfer(1'b1, (n + 2) % WORDS, pattern(n + 2, 3), "R9 write other bank");
      expect_hit((n + 1) % WORDS, 1'b1, "R9 kept");
      xfer(1'b0, (n + 1) % WORDS, '0, "R9 read la");
    end
    idle();

    // Final read-back: descending then ascending.
    for (int a = WORDS - 1; a >= 0; a--) xfer(1'b0, a, '0, "R7 descend readback");
    for (int a = 0; a < WORDS; a++) xfer(1'b0, a, '0, "R4 ascend readback");
    idle();
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog (all R) got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule